// File: doc/BRIEF.md
# Input Activity Monitor with Holdover and Output-Enable Control

This block watches a serial data input for activity. It runs on the loop clock and counts how many clock periods pass with no change on the input. When the input has been idle for a fixed number of periods, the block raises an alarm flag. The flag drops again as soon as a single change of either polarity reaches it. The data input is first brought into the clock domain through a synchroniser chain. Changes are then found by comparing one synchronised sample with the next.

Two steering outputs sit beside the alarm. The first is a holdover select, driven from an external request pin. It picks the source of the oscillator tuning value: the loop-filter path, or a fixed centre value. The second is a bank of four output enables, driven from an active-low high-impedance request. These enables decide whether the four clock and data drivers are active or released. The analog switching that these selects control lies outside the block.

Top module: `sig_loss_guard`

## Requirements
- R1: While `rst` is high on a rising edge of `clk_in`, the quiet counter is cleared and `los` is low after that edge.
- R2: After `data_in` changes once and is then held steady, `los` is low through the 258th rising edge of `clk_in` that follows the change and high from the 259th onward. This is two synchroniser stages, one compare stage and 256 quiet periods.
- R3: While `los` is high, one change on `data_in`, rising or falling, drives `los` low on the third rising edge after the change. No further count is needed.
- R4: Changes on `data_in` spaced exactly 256 clock periods apart keep `los` low indefinitely.
- R5: Once high, `los` stays high for as long as the input remains idle. The quiet counter saturates and does not wrap.
- R6: `ctrl_sel` is 0 (loop-filter path) when `losin` is 0 and 1 (fixed centre value) when `losin` is 1, whatever the state of `los`.
- R7: `out_en` bit 0 (main clock), bit 1 (divided clock), bit 2 (recovered clock) and bit 3 (recovered data) are all 1 when `hiz_n` is 1 and all 0 when `hiz_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Loop clock; one count per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 1 | Monitored data input, asynchronous |
| losin | input | 1 | Holdover request; 1 selects the centre value |
| hiz_n | input | 1 | Active-low request to release all outputs |
| los | output | 1 | Loss-of-activity alarm |
| ctrl_sel | output | 1 | Tuning source select: 0 loop path, 1 centre value |
| out_en | output | 4 | Driver enables: main, divided, recovered clock, recovered data |

## Verification
A counter that is off by one shows up as an alarm one period early or late against the 259-edge boundary. The bench probes that boundary on both sides. A counter that wraps instead of saturating makes the alarm drop on its own, hundreds of cycles after it rose. The long idle test catches this. A broken edge detector misses a change of one polarity, so the alarm fails to clear three edges after that change. Spaced changes placed exactly at the limit show whether the counter restarts cleanly on every edge.

// File: rtl/slg_pkg.sv
package slg_pkg;

    typedef enum logic {
        SEL_LOOP   = 1'b0,
        SEL_CENTRE = 1'b1
    } ctrl_src_e;

    typedef struct packed {
        logic rdata;
        logic rclk;
        logic divided;
        logic main;
    } out_en_t;

    function automatic int unsigned quiet_cnt_width(input int unsigned limit);
        return $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/slg_edge_sync.sv
module slg_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic edge_seen
);
    localparam int unsigned PW = SYNC_STAGES + 1;

    logic [PW-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[PW-2:0], din};
    end

    assign edge_seen = pipe[PW-1] ^ pipe[PW-2];

endmodule

// File: rtl/slg_quiet_timer.sv
module slg_quiet_timer #(
    parameter int unsigned QUIET_LIMIT = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_seen,
    output logic alarm
);
    localparam int unsigned CW = slg_pkg::quiet_cnt_width(QUIET_LIMIT);
    localparam logic [CW-1:0] LIM      = CW'(QUIET_LIMIT);
    localparam logic [CW-1:0] LIM_LAST = CW'(QUIET_LIMIT - 1);

    logic [CW-1:0] quiet_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_cnt <= '0;
            alarm     <= 1'b0;
        end else if (edge_seen) begin
            quiet_cnt <= '0;
            alarm     <= 1'b0;
        end else begin
            if (quiet_cnt != LIM) quiet_cnt <= quiet_cnt + 1'b1;
            if (quiet_cnt == LIM_LAST) alarm <= 1'b1;
        end
    end

    // R1: reset leaves counter clear and alarm low
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (quiet_cnt == '0 && !alarm));
    // R3: an edge drops the alarm on the next clock
    p_edge_clears_r3: assert property (@(posedge clk) disable iff (rst)
        edge_seen |=> !alarm);
    // R2: the alarm only rises when the count has reached the limit
    p_rise_at_limit_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm) |-> quiet_cnt == LIM);
    // R5: the alarm holds while idle, and the counter never passes the limit
    p_hold_while_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (alarm && !edge_seen) |=> alarm);
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        quiet_cnt <= LIM);

endmodule

// File: rtl/slg_out_ctrl.sv
module slg_out_ctrl
    import slg_pkg::*;
(
    input  logic      holdover_req,
    input  logic      release_n,
    output ctrl_src_e src_sel,
    output out_en_t   drv_en
);
    always_comb begin
        src_sel        = holdover_req ? SEL_CENTRE : SEL_LOOP;
        drv_en.main    = release_n;
        drv_en.divided = release_n;
        drv_en.rclk    = release_n;
        drv_en.rdata   = release_n;
    end
endmodule

// File: rtl/sig_loss_guard.sv
module sig_loss_guard
    import slg_pkg::*;
#(
    parameter int unsigned QUIET_LIMIT = 256,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_in,
    input  logic       rst,
    input  logic       data_in,
    input  logic       losin,
    input  logic       hiz_n,
    output logic       los,
    output logic       ctrl_sel,
    output logic [3:0] out_en
);
    logic      edge_seen;
    ctrl_src_e src_sel;
    out_en_t   drv_en;

    slg_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk_in), .rst(rst), .din(data_in), .edge_seen(edge_seen)
    );

    slg_quiet_timer #(.QUIET_LIMIT(QUIET_LIMIT)) u_timer (
        .clk(clk_in), .rst(rst), .edge_seen(edge_seen), .alarm(los)
    );

    slg_out_ctrl u_ctrl (
        .holdover_req(losin), .release_n(hiz_n),
        .src_sel(src_sel), .drv_en(drv_en)
    );

    assign ctrl_sel = src_sel;
    assign out_en   = drv_en;

    // R6: the tuning select tracks the holdover request
    p_sel_follows_r6: assert property (@(posedge clk_in) disable iff (rst)
        ctrl_sel == losin);
    // R7: the four driver enables move together with hiz_n
    p_enables_r7: assert property (@(posedge clk_in) disable iff (rst)
        out_en == {4{hiz_n}});

endmodule

// File: tb/test_sig_loss_guard.sv
module test_sig_loss_guard;
    logic       clk_in = 1'b0;
    logic       rst = 1'b1;
    logic       data_in = 1'b0;
    logic       losin = 1'b0;
    logic       hiz_n = 1'b1;
    logic       los;
    logic       ctrl_sel;
    logic [3:0] out_en;

    int n_chk = 0;
    int n_bad = 0;

    sig_loss_guard i_sig_loss_guard (
        .clk_in(clk_in), .rst(rst), .data_in(data_in), .losin(losin),
        .hiz_n(hiz_n), .los(los), .ctrl_sel(ctrl_sel), .out_en(out_en)
    );

    always #4 clk_in = ~clk_in;

    task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk_in);
        @(negedge clk_in);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        tick(3);
        chk({3'b0, los}, 4'b0, "R1 los low in reset");
        rst = 1'b0;
        tick(1);
        chk({3'b0, los}, 4'b0, "R1 los low after reset");
    endtask

    task automatic t_exact_limit;
        data_in = ~data_in;
        tick(258);
        chk({3'b0, los}, 4'b0, "R2 los low at edge 258");
        tick(1);
        chk({3'b0, los}, 4'b1, "R2 los high at edge 259");
    endtask

    task automatic t_clear(input string tag);
        data_in = ~data_in;
        tick(2);
        chk({3'b0, los}, 4'b1, {tag, " still high after 2 edges"});
        tick(1);
        chk({3'b0, los}, 4'b0, {tag, " low after 3 edges"});
        tick(255);
        chk({3'b0, los}, 4'b0, "R2 low through edge 258 after clear");
        tick(1);
        chk({3'b0, los}, 4'b1, "R2 high again at edge 259");
    endtask

    task automatic t_spaced;
        for (int i = 0; i < 6; i++) begin
            data_in = ~data_in;
            tick(256);
            chk({3'b0, los}, 4'b0, "R4 spaced edges keep los low");
        end
        tick(3);
        chk({3'b0, los}, 4'b1, "R4 idle after spaced edges raises los");
    endtask

    task automatic t_saturate;
        tick(700);
        chk({3'b0, los}, 4'b1, "R5 los holds through long idle");
        tick(300);
        chk({3'b0, los}, 4'b1, "R5 no wrap after 1000 idle edges");
    endtask

    task automatic t_sel;
        losin = 1'b0; #1;
        chk({3'b0, ctrl_sel}, 4'b0, "R6 loop path with losin 0");
        losin = 1'b1; #1;
        chk({3'b0, ctrl_sel}, 4'b1, "R6 centre value with losin 1");
        data_in = ~data_in;
        tick(3);
        chk({3'b0, ctrl_sel}, 4'b1, "R6 select ignores los");
        losin = 1'b0; #1;
        chk({3'b0, ctrl_sel}, 4'b0, "R6 back to loop path");
        tick(1);
    endtask

    task automatic t_outen;
        hiz_n = 1'b1; #1;
        chk(out_en, 4'b1111, "R7 all drivers enabled");
        hiz_n = 1'b0; #1;
        chk(out_en, 4'b0000, "R7 all drivers released");
        tick(2);
        chk(out_en, 4'b0000, "R7 release holds");
        hiz_n = 1'b1; #1;
        chk(out_en, 4'b1111, "R7 drivers re-enabled");
    endtask

    initial begin
        t_reset();
        t_exact_limit();
        t_clear("R3 rising change");
        t_clear("R3 falling change");
        t_spaced();
        t_saturate();
        t_sel();
        t_outen();
        rst = 1'b1;
        tick(1);
        chk({3'b0, los}, 4'b0, "R1 reset from alarm state");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule